// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block keeps a small table of message-signalled interrupt vectors, plus the pending-bit window that follows the table, in a single memory-mapped region. Software programs each vector through a register port that takes a byte offset, an access size and up to 64 bits of data. Each vector entry holds a 64-bit target address, a 32-bit message payload and a 32-bit control word whose lowest bit masks the vector. Reads come back on a separate valid strobe one cycle after the request.

Device logic raises an interrupt by presenting a vector index on the trigger input. The controller checks the function-level enables coming from configuration space, the index range and the mask bit of the entry. It then emits a one-cycle message strobe carrying an 8-bit destination taken from the entry address and an 8-bit vector taken from the entry payload. A trigger that is not allowed is discarded and leaves no pending state. The controller rejects accesses of the wrong size, misaligned accesses and accesses beyond the table, and it reads the pending-bit window as zeros.

Top module: `msix_vector_ctl`

## Requirements
- R1: Each entry takes 16 bytes at offset 16*index. Within an entry, byte 0 holds the address low word, byte 4 the address high word, byte 8 the message data and byte 12 the vector control word. An 8-byte access at byte 0 covers {high,low} address, and one at byte 8 covers {control,data} with the control word in bits 63:32. A single 8-byte write updates all 64 bits, and every write is visible to a read issued in the following cycle.
- R2: Only sizes of 4 and 8 bytes are accepted. A write of any other size changes nothing, and a read of any other size returns 64'hFFFF_FFFF_FFFF_FFFF.
- R3: An access must be aligned to its own size (offset bits 1:0 zero for 4 bytes, bits 2:0 zero for 8 bytes). A misaligned write changes nothing, and a misaligned read returns all ones.
- R4: An access whose entry index (offset/16) is at or beyond NUM_VEC does not write any entry. Such a read returns all ones unless R5 applies.
- R5: The pending window starts at NUM_VEC*16 rounded up to a multiple of 4096 and is 8*ceil(NUM_VEC/64) bytes long. A valid-size, aligned read inside it returns 0. A write to it has no effect, and a read past its end returns all ones.
- R6: After reset every entry reads as zero, except bit 0 of every vector control word, which reads as 1.
- R7: A trigger yields a message only when MSI-X is enabled, plain MSI is not enabled, the function mask is clear, the index is below NUM_VEC and bit 0 of that entry's control word is clear.
- R8: The message strobe rises in the cycle after an allowed trigger and lasts exactly one cycle per trigger. Its destination equals entry address bits 19:12, and its vector equals message data bits 7:0.
- R9: A suppressed trigger is dropped for good. Clearing the mask afterwards sends no message, and the pending window still reads 0.
- R10: A read result appears with regRdValid one cycle after regRdEn. A 4-byte read returns its word in bits 31:0, with bits 63:32 zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write request |
| regRdEn | input | 1 | Read request |
| regOffset | input | ADDR_W | Byte offset in the window |
| regSize | input | 4 | Access size in bytes |
| regWrData | input | 64 | Write data (4-byte writes use bits 31:0) |
| regRdValid | output | 1 | Read data valid |
| regRdData | output | 64 | Read data |
| msixEnable | input | 1 | MSI-X enable from configuration |
| funcMask | input | 1 | Function-wide mask from configuration |
| msiEnable | input | 1 | Plain MSI enabled |
| trigValid | input | 1 | Interrupt request |
| trigIndex | input | TRIG_W | Requested vector index |
| msgValid | output | 1 | Message strobe |
| msgDest | output | 8 | Message destination |
| msgVector | output | 8 | Message vector |

## Verification
Read data and the message strobe are both due exactly one clock after the request, and a write is due to be visible to the next access. Each scenario task therefore drives its inputs on a falling edge, lets one rising edge pass and samples on the following falling edge. The message strobe is sampled a second time one cycle later to show that it has already dropped. Suppressed triggers are followed by extra idle cycles and by a read of the pending window, which shows that no late message and no pending bit appeared.

// File: rtl/msix_pkg.sv
package msix_pkg;

  typedef enum logic [1:0] {
    RD_NONE  = 2'd0,
    RD_TABLE = 2'd1,
    RD_PBA   = 2'd2,
    RD_BAD   = 2'd3
  } rd_kind_e;

  // Strobes from the access/trigger control to the table datapath
  typedef struct packed {
    logic     wrEn;
    logic     wr64;
    logic [1:0] word;
    rd_kind_e rdKind;
    logic     rd64;
    logic     fire;
  } ctl_strobe_t;

endpackage

// File: rtl/msix_ctl.sv
module msix_ctl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 3,
  parameter int ADDR_W  = 16,
  parameter int TRIG_W  = 8,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regOffset,
  input  logic [3:0]        regSize,
  input  logic              msixEnable,
  input  logic              funcMask,
  input  logic              msiEnable,
  input  logic              trigValid,
  input  logic [TRIG_W-1:0] trigIndex,
  input  logic [NUM_VEC-1:0] maskBits,
  output ctl_strobe_t       strobe,
  output logic [IDX_W-1:0]  entryIdx,
  output logic [IDX_W-1:0]  fireIdx
);

  localparam int TBL_BYTES = NUM_VEC * 16;
  localparam int PBA_BASE  = ((TBL_BYTES + 4095) / 4096) * 4096;
  localparam int PBA_LEN   = ((NUM_VEC + 63) / 64) * 8;

  logic sizeOk, alignOk, inTable, inPba, accessOk;
  logic trigInRange, trigUnmasked, funcAllows;

  always_comb begin
    sizeOk   = (regSize == 4'd4) || (regSize == 4'd8);
    alignOk  = (regSize == 4'd8) ? (regOffset[2:0] == 3'b000)
                                 : (regOffset[1:0] == 2'b00);
    inTable  = (32'(regOffset) >> 4) < 32'(NUM_VEC);
    inPba    = (32'(regOffset) >= 32'(PBA_BASE)) &&
               (32'(regOffset) < 32'(PBA_BASE + PBA_LEN));
    accessOk = sizeOk && alignOk;
  end

  assign entryIdx = regOffset[IDX_W+3:4];
  assign fireIdx  = trigIndex[IDX_W-1:0];

  always_comb begin
    trigInRange  = 32'(trigIndex) < 32'(NUM_VEC);
    trigUnmasked = trigInRange && !maskBits[fireIdx];
    funcAllows   = msixEnable && !msiEnable && !funcMask;
  end

  always_comb begin
    strobe        = '0;
    strobe.wrEn   = regWrEn && accessOk && inTable;
    strobe.wr64   = (regSize == 4'd8);
    strobe.word   = regOffset[3:2];
    strobe.rd64   = (regSize == 4'd8);
    strobe.rdKind = RD_NONE;
    if (regRdEn) begin
      if (accessOk && inTable)     strobe.rdKind = RD_TABLE;
      else if (accessOk && inPba)  strobe.rdKind = RD_PBA;
      else                         strobe.rdKind = RD_BAD;
    end
    strobe.fire   = trigValid && funcAllows && trigUnmasked;
  end

  // A write strobe must never leave the control with an alignment violation
  p_wr_aligned_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (regOffset[1:0] == 2'b00));

  // A write strobe must address a real entry
  p_wr_in_table_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEn |-> (32'(entryIdx) < 32'(NUM_VEC)));

endmodule

// File: rtl/msix_dp.sv
module msix_dp
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 3,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_strobe_t       strobe,
  input  logic [IDX_W-1:0]  entryIdx,
  input  logic [IDX_W-1:0]  fireIdx,
  input  logic [63:0]       wrData,
  output logic [NUM_VEC-1:0] maskBits,
  output logic              rdValid,
  output logic [63:0]       rdData,
  output logic              msgValid,
  output logic [7:0]        msgDest,
  output logic [7:0]        msgVector
);

  logic [31:0] addrLo  [NUM_VEC];
  logic [31:0] addrHi  [NUM_VEC];
  logic [31:0] msgData [NUM_VEC];
  logic [31:0] vecCtrl [NUM_VEC];

  for (genvar i = 0; i < NUM_VEC; i++) begin : g_entry
    logic hit;
    assign hit = strobe.wrEn && (32'(entryIdx) == i);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        addrLo[i]  <= '0;
        addrHi[i]  <= '0;
        msgData[i] <= '0;
        vecCtrl[i] <= 32'h0000_0001;
      end else if (hit) begin
        if (strobe.wr64) begin
          if (!strobe.word[1]) begin
            addrLo[i] <= wrData[31:0];
            addrHi[i] <= wrData[63:32];
          end else begin
            msgData[i] <= wrData[31:0];
            vecCtrl[i] <= wrData[63:32];
          end
        end else begin
          case (strobe.word)
            2'd0:    addrLo[i]  <= wrData[31:0];
            2'd1:    addrHi[i]  <= wrData[31:0];
            2'd2:    msgData[i] <= wrData[31:0];
            default: vecCtrl[i] <= wrData[31:0];
          endcase
        end
      end
    end

    assign maskBits[i] = vecCtrl[i][0];
  end

  logic [63:0] rdNext;
  logic [31:0] rdWord;

  always_comb begin
    case (strobe.word)
      2'd0:    rdWord = addrLo[entryIdx];
      2'd1:    rdWord = addrHi[entryIdx];
      2'd2:    rdWord = msgData[entryIdx];
      default: rdWord = vecCtrl[entryIdx];
    endcase
    case (strobe.rdKind)
      RD_TABLE: begin
        if (strobe.rd64)
          rdNext = strobe.word[1] ? {vecCtrl[entryIdx], msgData[entryIdx]}
                                  : {addrHi[entryIdx], addrLo[entryIdx]};
        else
          rdNext = {32'h0, rdWord};
      end
      RD_PBA:  rdNext = '0;
      default: rdNext = '1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid   <= 1'b0;
      rdData    <= '0;
      msgValid  <= 1'b0;
      msgDest   <= '0;
      msgVector <= '0;
    end else begin
      rdValid  <= (strobe.rdKind != RD_NONE);
      if (strobe.rdKind != RD_NONE) rdData <= rdNext;
      msgValid <= strobe.fire;
      if (strobe.fire) begin
        msgDest   <= addrLo[fireIdx][19:12];
        msgVector <= msgData[fireIdx][7:0];
      end
    end
  end

  // Pending-window reads come back as zero
  p_pba_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(strobe.rdKind == RD_PBA)) |-> (rdData == 64'h0));

  // Rejected reads come back as all ones
  p_bad_ones_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && $past(strobe.rdKind == RD_BAD)) |-> (rdData == '1));

  // A message always follows a fire strobe from the control
  p_msg_from_fire_r8: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> $past(strobe.fire));

endmodule

// File: rtl/msix_vector_ctl.sv
module msix_vector_ctl
  import msix_pkg::*;
#(
  parameter int NUM_VEC = 3,
  parameter int ADDR_W  = 16,
  parameter int TRIG_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regOffset,
  input  logic [3:0]        regSize,
  input  logic [63:0]       regWrData,
  output logic              regRdValid,
  output logic [63:0]       regRdData,
  input  logic              msixEnable,
  input  logic              funcMask,
  input  logic              msiEnable,
  input  logic              trigValid,
  input  logic [TRIG_W-1:0] trigIndex,
  output logic              msgValid,
  output logic [7:0]        msgDest,
  output logic [7:0]        msgVector
);

  localparam int IDX_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

  ctl_strobe_t      strobe;
  logic [IDX_W-1:0] entryIdx;
  logic [IDX_W-1:0] fireIdx;
  logic [NUM_VEC-1:0] maskBits;

  msix_ctl #(
    .NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .TRIG_W(TRIG_W), .IDX_W(IDX_W)
  ) u_ctl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regOffset(regOffset), .regSize(regSize),
    .msixEnable(msixEnable), .funcMask(funcMask), .msiEnable(msiEnable),
    .trigValid(trigValid), .trigIndex(trigIndex),
    .maskBits(maskBits),
    .strobe(strobe), .entryIdx(entryIdx), .fireIdx(fireIdx)
  );

  msix_dp #(
    .NUM_VEC(NUM_VEC), .IDX_W(IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .entryIdx(entryIdx), .fireIdx(fireIdx),
    .wrData(regWrData),
    .maskBits(maskBits),
    .rdValid(regRdValid), .rdData(regRdData),
    .msgValid(msgValid), .msgDest(msgDest), .msgVector(msgVector)
  );

  // A message needs every function-level permission in the triggering cycle
  p_msg_permitted_r7: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> $past(trigValid && msixEnable && !msiEnable && !funcMask &&
                       (32'(trigIndex) < 32'(NUM_VEC))));

  // Read data only answers a read request
  p_rd_follows_req_r10: assert property (@(posedge clk) disable iff (!rstN)
    regRdValid |-> $past(regRdEn));

endmodule

// File: tb/msix_vector_ctl_bench.sv
module msix_vector_ctl_bench;

  localparam int NUM_VEC = 3;
  localparam int ADDR_W  = 16;
  localparam int TRIG_W  = 8;
  localparam logic [63:0] ONES = 64'hFFFF_FFFF_FFFF_FFFF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0, regRdEn = 1'b0;
  logic [ADDR_W-1:0] regOffset = '0;
  logic [3:0] regSize = 4'd4;
  logic [63:0] regWrData = '0;
  logic regRdValid;
  logic [63:0] regRdData;
  logic msixEnable = 1'b0, funcMask = 1'b0, msiEnable = 1'b0;
  logic trigValid = 1'b0;
  logic [TRIG_W-1:0] trigIndex = '0;
  logic msgValid;
  logic [7:0] msgDest, msgVector;

  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 1'b0;

  always #10 clk = ~clk;

  msix_vector_ctl #(.NUM_VEC(NUM_VEC), .ADDR_W(ADDR_W), .TRIG_W(TRIG_W)) u_msix_vector_ctl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regOffset(regOffset),
    .regSize(regSize), .regWrData(regWrData),
    .regRdValid(regRdValid), .regRdData(regRdData),
    .msixEnable(msixEnable), .funcMask(funcMask), .msiEnable(msiEnable),
    .trigValid(trigValid), .trigIndex(trigIndex),
    .msgValid(msgValid), .msgDest(msgDest), .msgVector(msgVector)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doWrite(input int off, input int size, input logic [63:0] data);
    @(negedge clk);
    regWrEn = 1'b1; regOffset = ADDR_W'(off); regSize = 4'(size); regWrData = data;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic doRead(input int off, input int size, output logic [63:0] data);
    @(negedge clk);
    regRdEn = 1'b1; regOffset = ADDR_W'(off); regSize = 4'(size);
    @(negedge clk);
    regRdEn = 1'b0;
    check("R10 valid", 64'(regRdValid), 64'd1);
    data = regRdData;
  endtask

  task automatic readExpect(input string req, input int off, input int size, input logic [63:0] exp);
    logic [63:0] got;
    doRead(off, size, got);
    check(req, got, exp);
  endtask

  task automatic trigExpect(input string req, input int idx, input bit expMsg,
                            input logic [7:0] expDest, input logic [7:0] expVec);
    @(negedge clk);
    trigValid = 1'b1; trigIndex = TRIG_W'(idx);
    @(negedge clk);
    trigValid = 1'b0;
    check(req, 64'(msgValid), 64'(expMsg));
    if (expMsg) begin
      check(req, 64'(msgDest), 64'(expDest));
      check(req, 64'(msgVector), 64'(expVec));
    end
    @(negedge clk);
    check({req, " one-cycle"}, 64'(msgValid), 64'd0);
  endtask

  task automatic testReset();
    readExpect("R6 ctrl0", 12, 4, 64'h1);
    readExpect("R6 ctrl1", 28, 4, 64'h1);
    readExpect("R6 ctrl2", 44, 4, 64'h1);
    readExpect("R6 addr0", 0, 8, 64'h0);
    readExpect("R6 data1", 24, 4, 64'h0);
  endtask

  task automatic testWord4();
    doWrite(16, 4, 64'hFFFF_FFFF_0005_3000);
    doWrite(20, 4, 64'h0000_0000_DEAD_BEEF);
    doWrite(24, 4, 64'h0000_0000_0000_0041);
    readExpect("R1 addrLo", 16, 4, 64'h0005_3000);
    readExpect("R10 zero-ext", 20, 4, 64'hDEAD_BEEF);
    readExpect("R1 addr64", 16, 8, 64'hDEAD_BEEF_0005_3000);
    readExpect("R1 ctl64", 24, 8, 64'h0000_0001_0000_0041);
  endtask

  task automatic testWord8();
    doWrite(32, 8, 64'h1234_5678_0007_7000);
    readExpect("R1 lo", 32, 4, 64'h0007_7000);
    readExpect("R1 hi", 36, 4, 64'h1234_5678);
    doWrite(40, 8, 64'h0000_0000_0000_0099);
    readExpect("R1 data", 40, 4, 64'h99);
    readExpect("R1 ctrl", 44, 4, 64'h0);
  endtask

  task automatic testSize();
    doWrite(0, 2, 64'hFFFF);
    doWrite(8, 1, 64'hFF);
    readExpect("R2 wr2 ignored", 0, 4, 64'h0);
    readExpect("R2 wr1 ignored", 8, 4, 64'h0);
    readExpect("R2 rd2", 0, 2, ONES);
    readExpect("R2 rd1", 16, 1, ONES);
  endtask

  task automatic testAlign();
    doWrite(4, 8, 64'hAAAA_AAAA_BBBB_BBBB);
    doWrite(2, 4, 64'h5555_5555);
    readExpect("R3 wr ignored hi", 4, 4, 64'h0);
    readExpect("R3 wr ignored lo", 0, 4, 64'h0);
    readExpect("R3 wr ignored data", 8, 4, 64'h0);
    readExpect("R3 rd4 mis", 18, 4, ONES);
    readExpect("R3 rd8 mis", 20, 8, ONES);
  endtask

  task automatic testRange();
    doWrite(48, 4, 64'h1111);
    doWrite(64, 8, 64'h2222_2222_3333_3333);
    doWrite(76, 4, 64'h0);
    readExpect("R4 no alias e0", 0, 8, 64'h0);
    readExpect("R4 no alias ctrl0", 12, 4, 64'h1);
    readExpect("R4 rd idx3", 48, 4, ONES);
    readExpect("R4 rd high", 16'h0FF8, 8, ONES);
  endtask

  task automatic testPba();
    readExpect("R5 pba8", 16'h1000, 8, 64'h0);
    readExpect("R5 pba4", 16'h1004, 4, 64'h0);
    readExpect("R5 past end", 16'h1008, 4, ONES);
    doWrite(16'h1000, 8, ONES);
    readExpect("R5 wr no effect", 16'h1000, 8, 64'h0);
    readExpect("R5 pba mis", 16'h1002, 4, ONES);
  endtask

  task automatic testFire();
    msixEnable = 1'b1; msiEnable = 1'b0; funcMask = 1'b0;
    trigExpect("R8 entry2", 2, 1'b1, 8'h77, 8'h99);
    trigExpect("R7 masked1", 1, 1'b0, 8'h0, 8'h0);
    doWrite(28, 4, 64'h0);
    trigExpect("R8 entry1", 1, 1'b1, 8'h53, 8'h41);
  endtask

  task automatic testGate();
    msixEnable = 1'b0;
    trigExpect("R7 msix off", 2, 1'b0, 8'h0, 8'h0);
    msixEnable = 1'b1; msiEnable = 1'b1;
    trigExpect("R7 msi on", 2, 1'b0, 8'h0, 8'h0);
    msiEnable = 1'b0; funcMask = 1'b1;
    trigExpect("R7 func mask", 2, 1'b0, 8'h0, 8'h0);
    funcMask = 1'b0;
    trigExpect("R7 idx3", 3, 1'b0, 8'h0, 8'h0);
    trigExpect("R7 idx200", 200, 1'b0, 8'h0, 8'h0);
    trigExpect("R7 reenabled", 2, 1'b1, 8'h77, 8'h99);
  endtask

  task automatic testDrop();
    doWrite(44, 4, 64'h1);
    trigExpect("R9 masked", 2, 1'b0, 8'h0, 8'h0);
    @(negedge clk);
    regWrEn = 1'b1; regOffset = 16'd44; regSize = 4'd4; regWrData = 64'h0;
    @(negedge clk);
    regWrEn = 1'b0;
    check("R9 no late msg", 64'(msgValid), 64'd0);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      check("R9 no late msg", 64'(msgValid), 64'd0);
    end
    readExpect("R9 pba clear", 16'h1000, 8, 64'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R6 rdvalid idle", 64'(regRdValid), 64'd0);
    check("R8 msg idle", 64'(msgValid), 64'd0);
    testReset();
    testWord4();
    testWord8();
    testSize();
    testAlign();
    testRange();
    testPba();
    testFire();
    testGate();
    testDrop();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
      $finish;
    end
  end

endmodule